// File: doc/BRIEF.md
# GF(2^233) Single-Cycle Squarer

This block squares an element of the binary field GF(2^233), held in polynomial basis, and returns the reduced square one clock later. Squaring in a field of characteristic two is a linear map. Each input coefficient moves from position i to position 2i, and the odd positions are left empty. The 465-bit product this gives is then folded back below degree 233 with a fixed XOR network built from the trinomial x^233 + x^74 + 1. No multiplier is involved, and the whole operation fits in one cycle.

A caller presents an operand with `in_valid` high. On the next rising edge the reduced square is captured into the output register, and `out_valid` rises for that cycle. Operands may arrive on every cycle. When no operand is presented, the output register keeps its last value.

Top module: `gf233_squarer`

## Requirements
- R1: Input coefficient i is placed at position 2i of the expanded polynomial, and odd positions are zero. For operands with no set bit above position 116, no reduction takes place, so the result is the plain interleave (for example 0xD gives 0x51) and every odd output bit is zero.
- R2: Each expanded coefficient at position k >= 233 is folded into positions k-233 and k-159, and folding repeats until nothing is left at or above 233. This is reduction modulo x^233 + x^74 + 1.
- R3: For arbitrary operands, the result equals a bit-serial shift-and-reduce product of the operand with itself modulo the same trinomial.
- R4: Squaring is linear: the square of (a XOR b) equals the square of a XOR the square of b.
- R5: Squaring 1 yields 1, and squaring 0 yields 0.
- R6: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high and reset low. The matching result appears on `out_elem` in that same cycle.
- R7: While `in_valid` is low, `out_elem` holds its value no matter what is on `in_elem`.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_elem` on the next edge. It takes precedence over an `in_valid` in the same cycle.
- R9: Single-bit operands at the fold boundary give fixed results. Bit 116 gives bit 232. Bit 117 gives bits 1 and 75. Bit 232 gives bits 72, 146 and 231, because bit 464 folds twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand on `in_elem` is to be squared |
| in_elem | input | 233 | Field element, polynomial basis, bit i = coefficient of x^i |
| out_valid | output | 1 | `out_elem` carries a fresh square this cycle |
| out_elem | output | 233 | Registered reduced square |

## Verification
Two events can land on the same clock edge. One is a reset, and the other is a new operand that would load the output register. The bench drives `rst` and `in_valid` high together, with a random nonzero operand, right after a valid result. It then expects a cleared output and a low `out_valid` with no queued result. A second collision happens inside the reduction network: the top coefficient of bit 232 folds into a position that must itself be folded again in the same cycle. The bench checks this against hand-derived bit positions and against the serial reference model.

// File: rtl/gf233_pkg.sv
package gf233_pkg;

    localparam int GF_W   = 233;
    localparam int GF_TAP = 74;

    typedef struct packed {
        logic            valid;
        logic [GF_W-1:0] elem;
    } gf_word_t;

    // Mask with every odd coefficient position set
    function automatic logic [GF_W-1:0] odd_positions();
        logic [GF_W-1:0] m;
        m = '0;
        for (int i = 1; i < GF_W; i += 2) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gf_sq_expand.sv
module gf_sq_expand #(
    parameter int FW = gf233_pkg::GF_W,
    localparam int EW = 2 * FW - 1
) (
    input  logic [FW-1:0] coef_in,
    output logic [EW-1:0] spread_out
);
    for (genvar i = 0; i < FW; i++) begin : g_spread
        assign spread_out[2*i] = coef_in[i];
        if (i < FW - 1) begin : g_gap
            assign spread_out[2*i+1] = 1'b0;
        end
    end
endmodule

// File: rtl/gf_sq_reduce.sv
module gf_sq_reduce #(
    parameter int FW  = gf233_pkg::GF_W,
    parameter int TAP = gf233_pkg::GF_TAP,
    localparam int EW = 2 * FW - 1
) (
    input  logic [EW-1:0] wide_in,
    output logic [FW-1:0] narrow_out
);
    logic [EW-1:0] acc;

    // Fold from the top down, so a fold that lands at or above FW is
    // picked up again by a later (lower) iteration in the same pass.
    always_comb begin
        acc = wide_in;
        for (int k = EW - 1; k >= FW; k--) begin
            acc[k-FW]     = acc[k-FW] ^ acc[k];
            acc[k-FW+TAP] = acc[k-FW+TAP] ^ acc[k];
        end
        narrow_out = acc[FW-1:0];
    end
endmodule

// File: rtl/gf233_squarer.sv
module gf233_squarer
    import gf233_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [GF_W-1:0] in_elem,
    output logic            out_valid,
    output logic [GF_W-1:0] out_elem
);
    localparam int EW = 2 * GF_W - 1;

    logic [EW-1:0]   spread;
    logic [GF_W-1:0] reduced;
    gf_word_t        res_q;

    gf_sq_expand #(.FW(GF_W)) u_expand (
        .coef_in    (in_elem),
        .spread_out (spread)
    );

    gf_sq_reduce #(.FW(GF_W), .TAP(GF_TAP)) u_reduce (
        .wide_in    (spread),
        .narrow_out (reduced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) res_q.elem <= reduced;
        end
    end

    assign out_valid = res_q.valid;
    assign out_elem  = res_q.elem;
endmodule

// File: rtl/gf233_squarer_chk.sv
module gf233_squarer_chk
    import gf233_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [GF_W-1:0] in_elem,
    input logic            out_valid,
    input logic [GF_W-1:0] out_elem
);
    localparam logic [GF_W-1:0] ODD_M = odd_positions();
    localparam logic [GF_W-1:0] ONE_E = GF_W'(1);

    p_valid_lag_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_elem));
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_elem == '0));
    p_one_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_elem == ONE_E) |=> out_elem == ONE_E);
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_elem == '0) |=> out_elem == '0);
    p_low_half_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_elem[GF_W-1:117] == '0) |=> (out_elem & ODD_M) == '0);
endmodule

bind gf233_squarer gf233_squarer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_elem   (in_elem),
    .out_valid (out_valid),
    .out_elem  (out_elem)
);

// File: tb/gf233_squarer_bench.sv
module gf233_squarer_bench;
    localparam int W = 233;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_elem = '0;
    logic         out_valid;
    logic [W-1:0] out_elem;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    item_t        sb_q[$];
    logic [W-1:0] seen[$];
    logic [W-1:0] hold_ref = '0;

    always #10 clk = ~clk;

    gf233_squarer u_gf233_squarer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_elem   (in_elem),
        .out_valid (out_valid),
        .out_elem  (out_elem)
    );

    // Serial reference: multiply a by a with shift-and-add, reducing each shift
    function automatic logic [W-1:0] ref_sq(logic [W-1:0] a);
        logic [W:0] r;
        r = '0;
        for (int i = W - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[W]) begin
                r[W]  = 1'b0;
                r[0]  = r[0] ^ 1'b1;
                r[74] = r[74] ^ 1'b1;
            end
            if (a[i]) r[W-1:0] = r[W-1:0] ^ a;
        end
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd_elem();
        logic [255:0] v;
        for (int j = 0; j < 8; j++) v[j*32 +: 32] = $urandom;
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] bit_at(int p);
        logic [W-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [W-1:0] a, logic [W-1:0] exp, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_elem  = a;
        sb_q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_elem  = rnd_elem();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: samples a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst) begin
                check(!out_valid && out_elem == '0, "R8 reset clear", out_elem, '0);
                hold_ref = '0;
            end else if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected out_valid", out_elem, '0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(out_elem == it.exp, it.tag, out_elem, it.exp);
                end
                seen.push_back(out_elem);
                hold_ref = out_elem;
            end else begin
                check(out_elem == hold_ref, "R7 hold while idle", out_elem, hold_ref);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R5 identity elements; R1 plain interleave
        send(bit_at(0), bit_at(0), "R5 square of one");
        send('0, '0, "R5 square of zero");
        send(W'(4'hD), W'(8'h51), "R1 interleave 0xD");
        a = '0;
        for (int i = 0; i < 117; i += 3) a[i] = 1'b1;
        b = '0;
        for (int i = 0; i < 117; i += 3) b[2*i] = 1'b1;
        send(a, b, "R1 low-half interleave");
        idle(2);

        // R9 / R2 boundary single bits
        send(bit_at(116), bit_at(232), "R9 bit116");
        send(bit_at(117), bit_at(1) | bit_at(75), "R9 bit117");
        send(bit_at(232), bit_at(72) | bit_at(146) | bit_at(231), "R9 R2 bit232 double fold");
        send(bit_at(200), ref_sq(bit_at(200)), "R2 bit200 fold");
        idle(3);

        // R3 random operands, back to back
        for (int i = 0; i < 40; i++) begin
            a = rnd_elem();
            send(a, ref_sq(a), "R3 random vs serial model");
        end
        send('1, ref_sq('1), "R3 all ones");
        idle(3);

        // R4 linearity
        for (int t = 0; t < 4; t++) begin
            a = rnd_elem();
            b = rnd_elem();
            send(a, ref_sq(a), "R4 operand a");
            send(b, ref_sq(b), "R4 operand b");
            send(a ^ b, ref_sq(a ^ b), "R4 operand a^b");
            idle(2);
            n = seen.size();
            check((seen[n-3] ^ seen[n-2]) == seen[n-1], "R4 linearity",
                  seen[n-1], seen[n-3] ^ seen[n-2]);
        end

        // R7 long idle with changing input
        idle(10);

        // R8 reset together with in_valid: reset wins, nothing queued
        a = rnd_elem();
        send(a, ref_sq(a), "R6 before reset");
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_elem  = bit_at(5) | rnd_elem();
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        idle(3);
        check(sb_q.size() == 0, "R6 R8 no stray result", W'(sb_q.size()), '0);

        // R6 resumes after reset
        a = rnd_elem();
        send(a, ref_sq(a), "R6 after reset");
        idle(3);
        check(sb_q.size() == 0, "R6 all results seen", W'(sb_q.size()), '0);
        finish_run();
    end
endmodule